// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block accepts byte-wide command writes from an asynchronous-style memory bus: active-low chip select, read strobe and write strobe, an address and an 8-bit data byte. It samples the bus in its own clock domain and commits a write at the end of the bus cycle, which is the first clock in which either chip select or write strobe has returned high. The byte and address committed are those present in the last clock of the active write.

The block keeps a read mode (array, status or identification), a phase for two-step program and erase sequences, and a status register. It sends single-cycle start, suspend and resume requests to an external program/erase sequencer. The sequencer reports back through completion, suspend-acknowledge and fault pulses. Read data comes from three places. It is the array byte supplied on an input port, a fixed identification byte chosen by address bit 0, or a snapshot of the status register that is taken when a read begins. While an operation is in progress, every read returns status.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, or after a cycle with `pwr_dn` high, the mode is array read, no operation is pending, and the status register reads 80h (ready, all flags clear).
- R2: A write is committed in the first clock after chip select and write strobe were both low, once either one is high. The byte and address used are those sampled in the last clock in which both were low.
- R3: When idle, FFh selects array read, 70h selects status read and 90h selects identification read. Every other byte that is not a setup code (50h, B0h, D0h, 00h and all unassigned values) leaves the mode unchanged.
- R4: In identification mode a read returns 20h when address bit 0 is 0 and F7h when it is 1, whatever the other address bits are.
- R5: 40h or 10h, followed by one more write, pulses `sq_prog_go` for one cycle. That second write's address appears on `sq_addr` and its byte on `sq_data`. Status then reads busy (bit 7 = 0) until `sq_done`.
- R6: 20h followed by D0h pulses `sq_erase_go` with the second write's address on `sq_addr`. 20h followed by any other byte starts nothing and sets bits 5 and 4.
- R7: While a program or erase is in progress, every read returns status regardless of mode. Only 70h, and during erase B0h, are acted on; all other bytes, including FFh and 90h, have no effect.
- R8: During an erase, B0h pulses `sq_susp_go`. `sq_susp_ack` then gives status C0h (bit 7 ready, bit 6 suspended). While suspended only FFh, 70h and D0h are accepted, and D0h pulses `sq_resume_go`, clears bit 6 and returns to busy.
- R9: Error bits 5 (erase), 4 (program) and 3 (supply low) are set by `sq_fail_erase`, `sq_fail_prog` and `sq_vpp_low`. They stay set until 50h is written while no operation is in progress, or until reset or power-down.
- R10: The status byte is {b7 ready, b6 suspended, b5, b4, b3, 3'b000}. Bits 2..0 always read 0.
- R11: A status read is captured in the first clock of the read. It holds for as long as chip select and read strobe stay low, even if the status register changes.
- R12: `dout_oe` is high one cycle after chip select and read strobe are low with write strobe high and `pwr_dn` low. When `dout_oe` is low, `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; clears mode, phase and status while high |
| ce_n | input | 1 | Bus chip select, active low |
| oe_n | input | 1 | Bus read strobe, active low |
| we_n | input | 1 | Bus write strobe, active low |
| addr | input | AW (19) | Bus address |
| din | input | 8 | Bus write byte |
| arr_data | input | 8 | Array byte for the current address |
| sq_done | input | 1 | Sequencer finished the program or erase |
| sq_susp_ack | input | 1 | Sequencer has suspended the erase |
| sq_fail_erase | input | 1 | Pulse: set erase error bit |
| sq_fail_prog | input | 1 | Pulse: set program error bit |
| sq_vpp_low | input | 1 | Pulse: set supply-low bit |
| sq_prog_go | output | 1 | One-cycle program start request |
| sq_erase_go | output | 1 | One-cycle erase start request |
| sq_susp_go | output | 1 | One-cycle erase suspend request |
| sq_resume_go | output | 1 | One-cycle erase resume request |
| sq_addr | output | AW (19) | Target address for program or erase |
| sq_data | output | 8 | Byte to program |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data valid/drive enable |

## Verification
The assertions assume that the bus inputs are already synchronous to `clk` and that a read (write strobe high) and a write never overlap. They also assume that the sequencer pulses `sq_done` or `sq_susp_ack` only while an operation is in progress, and never both in the same cycle. The stimulus drives every input on the falling clock edge and runs each bus access as a separate task that returns all strobes high before the next one begins. It raises sequencer pulses only after an operation has been started, or after a suspend has been requested.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [7:0]    arr_data,
  input  logic          sq_done,
  input  logic          sq_susp_ack,
  input  logic          sq_fail_erase,
  input  logic          sq_fail_prog,
  input  logic          sq_vpp_low,
  output logic          sq_prog_go,
  output logic          sq_erase_go,
  output logic          sq_susp_go,
  output logic          sq_resume_go,
  output logic [AW-1:0] sq_addr,
  output logic [7:0]    sq_data,
  output logic [7:0]    dout,
  output logic          dout_oe
);

  localparam logic [7:0] C_ARRAY  = 8'hFF;
  localparam logic [7:0] C_STAT   = 8'h70;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_CLR    = 8'h50;
  localparam logic [7:0] C_PROG_A = 8'h40;
  localparam logic [7:0] C_PROG_B = 8'h10;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] ID_LO    = 8'h20;
  localparam logic [7:0] ID_HI    = 8'hF7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PSET, PH_ESET, PH_PRUN, PH_ERUN, PH_SPEND, PH_SUSP
  } phase_t;

  typedef enum logic [1:0] {MD_ARRAY, MD_STAT, MD_IDENT} mode_t;

  phase_t phase, phase_n;
  mode_t  mode, mode_n;

  logic          wr_act, wr_q, cmd_stb;
  logic [AW-1:0] lat_addr;
  logic [7:0]    lat_data;
  logic          p_go, e_go, s_go, r_go;
  logic          clr_cmd, bad_conf, susp_set, susp_clr;
  logic          err_e, err_p, err_v, st_susp;
  logic          running;
  logic [7:0]    status_live;
  logic          rd_act, rd_q, stat_sel, sel_q;

  assign wr_act  = ~ce_n & ~we_n & ~pwr_dn;
  assign cmd_stb = wr_q & ~wr_act & ~pwr_dn;
  assign running = (phase == PH_PRUN) || (phase == PH_ERUN) || (phase == PH_SPEND);
  assign status_live = {~running, st_susp, err_e, err_p, err_v, 3'b000};

  assign rd_act   = ~ce_n & ~oe_n & we_n & ~pwr_dn;
  assign stat_sel = running | (mode == MD_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        lat_addr <= addr;
        lat_data <= din;
      end
    end
  end

  always_comb begin
    phase_n  = phase;
    mode_n   = mode;
    p_go     = 1'b0;
    e_go     = 1'b0;
    s_go     = 1'b0;
    r_go     = 1'b0;
    clr_cmd  = 1'b0;
    bad_conf = 1'b0;
    susp_set = 1'b0;
    susp_clr = 1'b0;
    if (cmd_stb) begin
      case (phase)
        PH_IDLE: begin
          case (lat_data)
            C_ARRAY:            mode_n  = MD_ARRAY;
            C_STAT:             mode_n  = MD_STAT;
            C_IDENT:            mode_n  = MD_IDENT;
            C_CLR:              clr_cmd = 1'b1;
            C_PROG_A, C_PROG_B: phase_n = PH_PSET;
            C_ERASE:            phase_n = PH_ESET;
            default: ;
          endcase
        end
        PH_PSET: begin
          p_go    = 1'b1;
          phase_n = PH_PRUN;
          mode_n  = MD_STAT;
        end
        PH_ESET: begin
          mode_n = MD_STAT;
          if (lat_data == C_CONF) begin
            e_go    = 1'b1;
            phase_n = PH_ERUN;
          end else begin
            bad_conf = 1'b1;
            phase_n  = PH_IDLE;
          end
        end
        PH_PRUN, PH_SPEND: begin
          if (lat_data == C_STAT) mode_n = MD_STAT;
        end
        PH_ERUN: begin
          if (lat_data == C_STAT) mode_n = MD_STAT;
          else if (lat_data == C_SUSP) begin
            s_go    = 1'b1;
            phase_n = PH_SPEND;
            mode_n  = MD_STAT;
          end
        end
        PH_SUSP: begin
          case (lat_data)
            C_ARRAY: mode_n = MD_ARRAY;
            C_STAT:  mode_n = MD_STAT;
            C_CONF: begin
              r_go     = 1'b1;
              susp_clr = 1'b1;
              phase_n  = PH_ERUN;
              mode_n   = MD_STAT;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (running && sq_done) begin
      phase_n = PH_IDLE;
      s_go    = 1'b0;
    end else if (phase == PH_SPEND && sq_susp_ack) begin
      phase_n  = PH_SUSP;
      susp_set = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      mode         <= MD_ARRAY;
      err_e        <= 1'b0;
      err_p        <= 1'b0;
      err_v        <= 1'b0;
      st_susp      <= 1'b0;
      sq_prog_go   <= 1'b0;
      sq_erase_go  <= 1'b0;
      sq_susp_go   <= 1'b0;
      sq_resume_go <= 1'b0;
      sq_addr      <= '0;
      sq_data      <= '0;
    end else if (pwr_dn) begin
      phase        <= PH_IDLE;
      mode         <= MD_ARRAY;
      err_e        <= 1'b0;
      err_p        <= 1'b0;
      err_v        <= 1'b0;
      st_susp      <= 1'b0;
      sq_prog_go   <= 1'b0;
      sq_erase_go  <= 1'b0;
      sq_susp_go   <= 1'b0;
      sq_resume_go <= 1'b0;
    end else begin
      phase        <= phase_n;
      mode         <= mode_n;
      err_e        <= (err_e & ~clr_cmd) | sq_fail_erase | bad_conf;
      err_p        <= (err_p & ~clr_cmd) | sq_fail_prog | bad_conf;
      err_v        <= (err_v & ~clr_cmd) | sq_vpp_low;
      if (susp_set)      st_susp <= 1'b1;
      else if (susp_clr) st_susp <= 1'b0;
      sq_prog_go   <= p_go;
      sq_erase_go  <= e_go;
      sq_susp_go   <= s_go;
      sq_resume_go <= r_go;
      if (p_go || e_go) begin
        sq_addr <= lat_addr;
        sq_data <= lat_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      sel_q   <= 1'b0;
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      rd_q    <= rd_act;
      sel_q   <= stat_sel;
      dout_oe <= rd_act;
      if (!rd_act)
        dout <= '0;
      else if (stat_sel) begin
        if (!rd_q || !sel_q) dout <= status_live;
      end else if (mode == MD_IDENT)
        dout <= addr[0] ? ID_HI : ID_LO;
      else
        dout <= arr_data;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_dn,
  input logic       rd_act,
  input logic       rd_q,
  input logic       stat_sel,
  input logic       sel_q,
  input logic       running,
  input logic       clr_cmd,
  input logic       err_e,
  input logic       err_p,
  input logic       err_v,
  input logic       st_susp,
  input logic       sq_prog_go,
  input logic       sq_erase_go,
  input logic       sq_susp_go,
  input logic       sq_resume_go,
  input logic [7:0] dout,
  input logic       dout_oe
);

  a_r1_pwrdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!running && !st_susp && !err_e && !err_p && !err_v));

  a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sq_prog_go, sq_erase_go, sq_susp_go, sq_resume_go}));

  a_r5_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sq_prog_go |-> (running && !st_susp));

  a_r6_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sq_erase_go |-> running);

  a_r7_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && running && $past(running)) |-> (dout[7] == 1'b0 && dout[2:0] == 3'b000));

  a_r8_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sq_resume_go |-> (running && !st_susp));

  a_r8_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    st_susp |-> !running);

  a_r9_sticky_e: assert property (@(posedge clk) disable iff (!rst_n)
    (err_e && !clr_cmd && !pwr_dn) |=> err_e);

  a_r9_sticky_p: assert property (@(posedge clk) disable iff (!rst_n)
    (err_p && !clr_cmd && !pwr_dn) |=> err_p);

  a_r9_sticky_v: assert property (@(posedge clk) disable iff (!rst_n)
    (err_v && !clr_cmd && !pwr_dn) |=> err_v);

  a_r11_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_act) && $past(rd_q) && $past(stat_sel) && $past(sel_q)) |-> $stable(dout));

  a_r12_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> dout_oe);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 8'h00));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .rd_act(rd_act), .rd_q(rd_q),
  .stat_sel(stat_sel), .sel_q(sel_q), .running(running), .clr_cmd(clr_cmd),
  .err_e(err_e), .err_p(err_p), .err_v(err_v), .st_susp(st_susp),
  .sq_prog_go(sq_prog_go), .sq_erase_go(sq_erase_go), .sq_susp_go(sq_susp_go),
  .sq_resume_go(sq_resume_go), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int AW = 19;
  localparam logic [7:0] ARR = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, arr_data = ARR;
  logic sq_done = 0, sq_susp_ack = 0, sq_fail_erase = 0, sq_fail_prog = 0, sq_vpp_low = 0;
  logic sq_prog_go, sq_erase_go, sq_susp_go, sq_resume_go;
  logic [AW-1:0] sq_addr;
  logic [7:0] sq_data, dout;
  logic dout_oe;

  int tests = 0, fails = 0;
  int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
  logic [AW-1:0] go_addr = '0;
  logic [7:0] go_data = '0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .arr_data(arr_data), .sq_done(sq_done),
    .sq_susp_ack(sq_susp_ack), .sq_fail_erase(sq_fail_erase), .sq_fail_prog(sq_fail_prog),
    .sq_vpp_low(sq_vpp_low), .sq_prog_go(sq_prog_go), .sq_erase_go(sq_erase_go),
    .sq_susp_go(sq_susp_go), .sq_resume_go(sq_resume_go), .sq_addr(sq_addr),
    .sq_data(sq_data), .dout(dout), .dout_oe(dout_oe)
  );

  always @(negedge clk) begin
    if (sq_prog_go)   begin n_prog++;  go_addr = sq_addr; go_data = sq_data; end
    if (sq_erase_go)  begin n_erase++; go_addr = sq_addr; end
    if (sq_susp_go)   n_susp++;
    if (sq_resume_go) n_res++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_first = 1'b0);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); @(negedge clk);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    din = 8'hEE; addr = ~a;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
    v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sq_done = 1'b1;
      1: sq_susp_ack = 1'b1;
      2: sq_fail_erase = 1'b1;
      3: sq_fail_prog = 1'b1;
      default: sq_vpp_low = 1'b1;
    endcase
    @(negedge clk);
    sq_done = 0; sq_susp_ack = 0; sq_fail_erase = 0; sq_fail_prog = 0; sq_vpp_low = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, e;
    int k;
    do_reset();
    do_read(19'h1, v);
    chk("R1 reset array mode", v, ARR);
    chk("R12 oe low after read", {dout_oe, dout}, 9'h000);
    do_write(0, 8'h70);
    do_read(0, v);
    chk("R1 R10 reset status", v, 8'h80);

    for (int c = 0; c < 256; c++) begin
      if (c == 8'h40 || c == 8'h10 || c == 8'h20) continue;
      do_reset();
      do_write(0, 8'h90);
      do_write(0, c[7:0]);
      do_read(19'h1, v);
      e = (c == 8'hFF) ? ARR : (c == 8'h70) ? 8'h80 : 8'hF7;
      chk($sformatf("R3 idle code %02h", c), v, e);
    end

    do_reset();
    do_write(0, 8'h90);
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 32'h9E37) ^ (i << 11));
      do_read(a, v);
      chk("R4 ident byte", v, a[0] ? 8'hF7 : 8'h20);
    end

    do_reset();
    k = n_prog;
    do_write(0, 8'h40);
    do_write(19'h7ABCD, 8'h3C, 1'b1);
    chk("R5 R2 prog go count (ce first)", n_prog, k + 1);
    chk("R5 R2 prog addr", go_addr, 19'h7ABCD);
    chk("R5 R2 prog data", go_data, 8'h3C);
    do_read(19'h1, v);
    chk("R7 busy read gives status", v, 8'h00);
    do_write(0, 8'hFF);
    do_read(19'h1, v);
    chk("R7 FF ignored while busy", v, 8'h00);
    pulse(3);
    pulse(0);
    do_read(19'h1, v);
    chk("R5 R9 done with prog error", v, 8'h90);
    do_write(0, 8'h50);
    do_write(0, 8'h10);
    do_write(19'h00001, 8'hC3);
    chk("R5 R2 alt prog count", n_prog, k + 2);
    chk("R5 R2 alt prog data", {go_addr, go_data}, {19'h00001, 8'hC3});
    pulse(0);
    do_read(0, v);
    chk("R9 clear then prog ok", v, 8'h80);

    do_reset();
    k = n_erase;
    do_write(0, 8'h20);
    do_write(19'h4321F, 8'hD0);
    chk("R6 erase go count", n_erase, k + 1);
    chk("R6 erase addr", go_addr, 19'h4321F);

    do_reset();
    k = n_erase;
    do_write(0, 8'h20);
    do_write(19'h11111, 8'h33);
    chk("R6 bad confirm no start", n_erase, k);
    do_read(0, v);
    chk("R6 bad confirm flags", v, 8'hB0);
    do_write(0, 8'hFF);
    do_read(19'h1, v);
    chk("R3 array after bad confirm", v, ARR);
    do_write(0, 8'h70);
    do_read(0, v);
    chk("R9 flags stay set", v, 8'hB0);
    do_write(0, 8'h50);
    do_read(0, v);
    chk("R9 clear command", v, 8'h80);

    for (int c = 0; c < 256; c++) begin
      do_reset();
      do_write(0, 8'h20);
      do_write(19'h2000, 8'hD0);
      k = n_susp;
      do_write(19'h1, c[7:0]);
      do_read(19'h1, v);
      chk($sformatf("R7 erase busy code %02h", c), v, 8'h00);
      chk($sformatf("R8 suspend req code %02h", c), n_susp, k + ((c == 8'hB0) ? 1 : 0));
      pulse(0);
      do_read(19'h1, v);
      chk($sformatf("R7 mode kept code %02h", c), v, 8'h80);
    end

    for (int c = 0; c < 256; c++) begin
      do_reset();
      do_write(0, 8'h20);
      do_write(19'h12345, 8'hD0);
      do_write(0, 8'hB0);
      pulse(1);
      k = n_res;
      do_write(19'h1, c[7:0]);
      do_read(19'h1, v);
      e = (c == 8'hFF) ? ARR : (c == 8'hD0) ? 8'h00 : 8'hC0;
      chk($sformatf("R8 suspended code %02h", c), v, e);
      chk($sformatf("R8 resume req code %02h", c), n_res, k + ((c == 8'hD0) ? 1 : 0));
    end

    do_reset();
    do_write(0, 8'h20);
    do_write(0, 8'hD0);
    pulse(2);
    do_read(0, v);
    chk("R9 erase error while busy", v, 8'h20);
    do_write(0, 8'h50);
    pulse(0);
    do_read(0, v);
    chk("R9 clear ignored while busy", v, 8'hA0);
    pulse(4);
    do_read(0, v);
    chk("R9 R10 supply low bit", v, 8'hA8);

    do_write(0, 8'h70);
    @(negedge clk); addr = 0; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 snapshot first", dout, 8'hA8);
    sq_fail_prog = 1'b1;
    @(negedge clk); sq_fail_prog = 1'b0;
    @(negedge clk);
    chk("R11 snapshot held", dout, 8'hA8);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    do_read(0, v);
    chk("R11 new snapshot", v, 8'hB8);

    do_write(0, 8'h90);
    @(negedge clk); pwr_dn = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 no drive in power-down", dout_oe, 1'b0);
    ce_n = 1'b1; oe_n = 1'b1; pwr_dn = 1'b0;
    @(negedge clk);
    do_read(19'h1, v);
    chk("R1 array after power-down", v, ARR);
    do_write(0, 8'h70);
    do_read(0, v);
    chk("R1 status after power-down", v, 8'h80);

    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 no drive during write", {dout_oe, dout}, 9'h000);
    din = 8'h00;
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule